// File: doc/BRIEF.md
# Debug-Port JTAG Scan Target

This block is the target end of a debug-port JTAG link. It runs a full IEEE 1149.1 TAP controller on the test clock and an instruction register that selects one of five scan chains: a one-bit bypass chain, a fixed identification word, and three 35-bit chains. Two of the 35-bit chains carry access requests to the debug-port registers and to the access-port registers. The third carries abort requests. Boundary-scan instructions are not implemented, and any code outside the supported set falls back to bypass.

An access request is shifted in as one 35-bit word. On Update-DR the block splits it into write data, a two-bit register address and a read/write flag, and offers it to an internal register port as a one-cycle strobe. The outcome is not returned on the same scan. The next capture loads the most recent read data returned by the port, together with a 3-bit acknowledge. The acknowledge reads WAIT if the previous request was dropped because the port was busy, and OK otherwise.

Top module: `dpjt_scan_target`

## Requirements
- R1: A 4-bit instruction selects the data chain between TDI and TDO: 1111 selects bypass (1 bit), 1110 selects identification (32 bits), 1010 selects debug-port access, 1011 selects access-port access and 1000 selects abort (35 bits each). Every other code selects bypass.
- R2: In Capture-IR the instruction shift register loads 0001. Instructions are shifted least significant bit first and take effect on Update-IR.
- R3: While trst_n is low, and on every clock spent in Test-Logic-Reset, the instruction becomes 1110 (identification).
- R4: Capture-DR under the identification instruction loads 0x3BA00477. That is version 0x3 in [31:28], part 0xBA00 in [27:12], manufacturer 0x23B in [11:1] and a 1 in bit 0.
- R5: On the rising TCK edge in Update-DR under an access instruction with port_busy low, req_valid is high for exactly the next TCK cycle. Alongside it, req_wdata carries scan bits [34:3], req_addr carries bits [2:1] (register address A[3:2]; on the debug port 01 is control/status, 10 is select, 11 is read buffer and 00 is reserved), and req_rnw carries bit 0 (1 means read). req_ap is 1 for 1011 and 0 for 1010.
- R6: Capture-DR under either access instruction loads bits [34:3] with the rsp_rdata value latched on the most recent rising edge where rsp_valid was high (zero after reset), and bits [2:0] with the acknowledge.
- R7: If port_busy is high at the Update-DR edge of an access scan, the request is dropped (req_valid stays low) and the next access capture returns acknowledge 001 (WAIT). The next accepted request restores 010 (OK). No other acknowledge code is ever produced.
- R8: Under instruction 1000, Update-DR with scan bit 3 (abort flag, data bit 0) set drives abort_req high for exactly one TCK cycle, whatever the state of port_busy, and never raises req_valid. Capture-DR under 1000 loads all zeros.
- R9: TDO shifts out the least significant bit first and changes only on falling TCK edges. tdo_en is high only while the controller is in Shift-DR or Shift-IR.
- R10: The bypass chain captures 0 and delays TDI by exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable (high only in shift states) |
| req_valid | output | 1 | One-cycle strobe for an access request |
| req_ap | output | 1 | Request targets the access port (1) or the debug port (0) |
| req_addr | output | 2 | Register address A[3:2] |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | DATA_W | Write data |
| port_busy | input | 1 | Register port cannot accept a request |
| rsp_valid | input | 1 | rsp_rdata holds a completed read result |
| rsp_rdata | input | DATA_W | Read result from the register port |
| abort_req | output | 1 | One-cycle abort strobe |

## Verification
Every result is tied to a fixed TCK edge, and the bench samples each one 5 ns after the falling edge that follows that edge. Captured values appear on TDO from the first Shift-DR cycle, one bit per cycle, and each bit is sampled before the rising edge that shifts it out. The bench also re-reads TDO 2 ns after each rising edge to confirm it did not move there. req_valid and abort_req are checked in the single TCK cycle after the Update-DR edge and again in the cycle after that, which must show them low. Because results are pipelined, a response is always checked on the scan after its request, and the acknowledge for a busy drop is checked on the following access scan.

// File: rtl/dpjt_pkg.sv
package dpjt_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_e;

   typedef enum logic [2:0] {
      CH_BYP, CH_IDW, CH_DPA, CH_APA, CH_ABT
   } chain_e;

   localparam logic [3:0] OP_BYP = 4'b1111;
   localparam logic [3:0] OP_IDW = 4'b1110;
   localparam logic [3:0] OP_DPA = 4'b1010;
   localparam logic [3:0] OP_APA = 4'b1011;
   localparam logic [3:0] OP_ABT = 4'b1000;

   localparam logic [2:0] ACK_WAIT = 3'b001;
   localparam logic [2:0] ACK_OK   = 3'b010;

   localparam int unsigned REQ_HDR_W = 3;

endpackage

// File: rtl/dpjt_tap_ctrl.sv
module dpjt_tap_ctrl
   import dpjt_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_e st
);

   tap_st_e st_nxt;

   always_comb begin
      unique case (st)
         ST_TLR:    st_nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    st_nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: st_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: st_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: st_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: st_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: st_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: st_nxt = tms ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: st_nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: st_nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: st_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: st_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: st_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: st_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: st_nxt = tms ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: st_nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   st_nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= st_nxt;
   end

   // R3: five clocks with TMS high always land in Test-Logic-Reset
   assert_tms_high_reset_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (tms && st == ST_SEL_IR) |=> (st == ST_TLR));

endmodule

// File: rtl/dpjt_instr.sv
module dpjt_instr
   import dpjt_pkg::*;
#(
   parameter int unsigned IR_W         = 4,
   parameter bit          STRICT_UPPER = 1'b1
)(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tdi,
   input  tap_st_e st,
   output logic    ir_lsb,
   output chain_e  chain
);

   localparam logic [IR_W-1:0] IR_RST = IR_W'(OP_IDW);
   localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

   logic [IR_W-1:0] ir_sr;
   logic [IR_W-1:0] ir_q;
   logic            upper_ok;

   generate
      if (IR_W < 4) begin : g_bad_w
         $error("dpjt_instr: IR_W must be at least 4");
      end
      if (IR_W > 4 && STRICT_UPPER) begin : g_strict
         assign upper_ok = (ir_q[IR_W-1:4] == '0);
      end else begin : g_loose
         assign upper_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
         ir_q  <= IR_RST;
      end else begin
         unique case (st)
            ST_TLR:    ir_q  <= IR_RST;
            ST_CAP_IR: ir_sr <= IR_CAP;
            ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            ST_UPD_IR: ir_q  <= ir_sr;
            default:   ;
         endcase
      end
   end

   always_comb begin
      chain = CH_BYP;
      if (upper_ok) begin
         unique case (ir_q[3:0])
            OP_IDW:  chain = CH_IDW;
            OP_DPA:  chain = CH_DPA;
            OP_APA:  chain = CH_APA;
            OP_ABT:  chain = CH_ABT;
            default: chain = CH_BYP;
         endcase
      end
   end

   assign ir_lsb = ir_sr[0];

   assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_IR) |=> (ir_sr == IR_CAP));

   assert_tlr_idcode_R3: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |=> (chain == CH_IDW));

endmodule

// File: rtl/dpjt_chains.sv
module dpjt_chains
   import dpjt_pkg::*;
#(
   parameter int unsigned     DATA_W = 32,
   parameter logic [DATA_W-1:0] IDCODE = 32'h3BA00477
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tdi,
   input  tap_st_e           st,
   input  chain_e            chain,
   output logic              dr_lsb,
   output logic              req_valid,
   output logic              req_ap,
   output logic [1:0]        req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              port_busy,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic              abort_req
);

   localparam int ACC_W = DATA_W + REQ_HDR_W;

   logic [ACC_W-1:0]  sr;
   logic [ACC_W-1:0]  sr_nxt;
   logic [DATA_W-1:0] last_rd;
   logic              dropped;
   logic              is_acc;
   int                len;

   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("dpjt_chains: DATA_W must be at least 8");
      end
   endgenerate

   assign is_acc = (chain == CH_DPA) || (chain == CH_APA);

   always_comb begin
      unique case (chain)
         CH_BYP:  len = 1;
         CH_IDW:  len = DATA_W;
         default: len = ACC_W;
      endcase
   end

   // TDI enters at the top of the selected chain; bits above it read as zero
   generate
      for (genvar b = 0; b < ACC_W; b++) begin : g_bit
         if (b == ACC_W - 1) begin : g_top
            assign sr_nxt[b] = (len == ACC_W) ? tdi : 1'b0;
         end else begin : g_mid
            assign sr_nxt[b] = (b == len - 1) ? tdi :
                               ((b < len - 1) ? sr[b+1] : 1'b0);
         end
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr        <= '0;
         last_rd   <= '0;
         dropped   <= 1'b0;
         req_valid <= 1'b0;
         req_ap    <= 1'b0;
         req_addr  <= '0;
         req_rnw   <= 1'b0;
         req_wdata <= '0;
         abort_req <= 1'b0;
      end else begin
         req_valid <= 1'b0;
         abort_req <= 1'b0;
         if (rsp_valid) last_rd <= rsp_rdata;
         unique case (st)
            ST_CAP_DR: begin
               unique case (chain)
                  CH_IDW:         sr <= ACC_W'(IDCODE);
                  CH_DPA, CH_APA: sr <= {last_rd, dropped ? ACK_WAIT : ACK_OK};
                  default:        sr <= '0;
               endcase
            end
            ST_SHF_DR: sr <= sr_nxt;
            ST_UPD_DR: begin
               if (is_acc) begin
                  if (port_busy) begin
                     dropped <= 1'b1;
                  end else begin
                     dropped   <= 1'b0;
                     req_valid <= 1'b1;
                     req_ap    <= (chain == CH_APA);
                     req_wdata <= sr[ACC_W-1:REQ_HDR_W];
                     req_addr  <= sr[2:1];
                     req_rnw   <= sr[0];
                  end
               end else if (chain == CH_ABT) begin
                  abort_req <= sr[REQ_HDR_W];
               end
            end
            default: ;
         endcase
      end
   end

   assign dr_lsb = sr[0];

   assert_ack_legal_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_DR && is_acc) |=> (sr[2:0] == ACK_OK || sr[2:0] == ACK_WAIT));

   assert_busy_drop_R7: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_UPD_DR && is_acc && port_busy) |=> !req_valid);

   assert_req_pulse_R5: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |=> !req_valid);

   assert_abort_pulse_R8: assert property (@(posedge tck) disable iff (!trst_n)
      abort_req |=> (!abort_req && !req_valid));

   assert_idcode_cap_R4: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_CAP_DR && chain == CH_IDW) |=> (sr[DATA_W-1:0] == IDCODE));

endmodule

// File: rtl/dpjt_scan_target.sv
module dpjt_scan_target
   import dpjt_pkg::*;
#(
   parameter int unsigned       DATA_W       = 32,
   parameter int unsigned       IR_W         = 4,
   parameter bit                STRICT_UPPER = 1'b1,
   parameter logic [DATA_W-1:0] IDCODE       = 32'h3BA00477
)(
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_en,
   output logic              req_valid,
   output logic              req_ap,
   output logic [1:0]        req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              port_busy,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic              abort_req
);

   tap_st_e st;
   chain_e  chain;
   logic    ir_lsb;
   logic    dr_lsb;

   generate
      if (IDCODE[0] != 1'b1) begin : g_bad_id
         $error("dpjt_scan_target: IDCODE bit 0 must be 1");
      end
   endgenerate

   dpjt_tap_ctrl u_tap (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .st     (st)
   );

   dpjt_instr #(
      .IR_W         (IR_W),
      .STRICT_UPPER (STRICT_UPPER)
   ) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .st     (st),
      .ir_lsb (ir_lsb),
      .chain  (chain)
   );

   dpjt_chains #(
      .DATA_W (DATA_W),
      .IDCODE (IDCODE)
   ) u_dr (
      .tck       (tck),
      .trst_n    (trst_n),
      .tdi       (tdi),
      .st        (st),
      .chain     (chain),
      .dr_lsb    (dr_lsb),
      .req_valid (req_valid),
      .req_ap    (req_ap),
      .req_addr  (req_addr),
      .req_rnw   (req_rnw),
      .req_wdata (req_wdata),
      .port_busy (port_busy),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .abort_req (abort_req)
   );

   // Output stage launches on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= (st == ST_SHF_IR) ? ir_lsb : dr_lsb;
         tdo_en <= (st == ST_SHF_IR) || (st == ST_SHF_DR);
      end
   end

   assert_tdo_idle_R9: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_RTI && $past(st) == ST_RTI) |-> !tdo_en);

endmodule

// File: tb/dpjt_scan_target_tb.sv
module dpjt_scan_target_tb;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo, tdo_en;
   logic        req_valid, req_ap, req_rnw, abort_req;
   logic [1:0]  req_addr;
   logic [31:0] req_wdata;
   logic        port_busy = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   int   total = 0;
   int   bad = 0;
   logic last_en;
   logic edge_moved = 1'b0;

   always #10 tck = ~tck;

   dpjt_scan_target u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr), .req_rnw(req_rnw),
      .req_wdata(req_wdata), .port_busy(port_busy), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .abort_req(abort_req)
   );

   // instruction code, expected 40-bit TDO stream for a TDI stream of 40'h1
   localparam logic [43:0] VEC [0:9] = '{
      {4'b1111, 40'h00_0000_0002},
      {4'b1110, 40'h01_3BA0_0477},
      {4'b1010, 40'h08_0000_0002},
      {4'b1011, 40'h08_0000_0002},
      {4'b1000, 40'h08_0000_0000},
      {4'b0000, 40'h00_0000_0002},
      {4'b0001, 40'h00_0000_0002},
      {4'b0010, 40'h00_0000_0002},
      {4'b0101, 40'h00_0000_0002},
      {4'b1100, 40'h00_0000_0002}
   };

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tclk(input logic m, input logic d, output logic o);
      @(negedge tck);
      tms = m;
      tdi = d;
      #5;
      o = tdo;
      last_en = tdo_en;
      @(posedge tck);
      #2;
      if (tdo !== o) edge_moved = 1'b1;
   endtask

   task automatic settle();
      @(negedge tck);
      #5;
   endtask

   task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
      logic b;
      tclk(1, 0, b); tclk(1, 0, b); tclk(0, 0, b); tclk(0, 0, b);
      for (int i = 0; i < 4; i++) begin
         tclk(i == 3, code[i], b);
         cap[i] = b;
      end
      tclk(1, 0, b); tclk(0, 0, b);
   endtask

   task automatic scan_dr(input logic [39:0] din, input int n, output logic [39:0] dout,
                          output logic en_all);
      logic b;
      dout = '0;
      en_all = 1'b1;
      tclk(1, 0, b); tclk(0, 0, b); tclk(0, 0, b);
      for (int i = 0; i < n; i++) begin
         tclk(i == n - 1, din[i], b);
         dout[i] = b;
         en_all &= last_en;
      end
      tclk(1, 0, b); tclk(0, 0, b);
   endtask

   initial begin
      logic [3:0]  icap;
      logic [39:0] dout;
      logic        en;
      logic        b;

      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      settle();
      chk(tdo_en == 1'b0 && req_valid == 1'b0 && abort_req == 1'b0, "R9 reset outputs idle",
          {61'd0, tdo_en, req_valid, abort_req}, 64'd0);
      tclk(0, 0, b);

      // R3/R4: identification word without any instruction scan
      scan_dr(40'h0, 32, dout, en);
      chk(dout[31:0] == 32'h3BA00477, "R3 R4 default instruction is identification",
          {24'd0, dout}, 64'h3BA00477);
      chk(en == 1'b1, "R9 tdo_en high through Shift-DR", {63'd0, en}, 64'd1);
      settle();
      chk(tdo_en == 1'b0, "R9 tdo_en low outside shift", {63'd0, tdo_en}, 64'd0);

      // table of instruction codes vs chain contents and length
      for (int v = 0; v < 10; v++) begin
         scan_ir(VEC[v][43:40], icap);
         chk(icap == 4'b0001, "R2 Capture-IR pattern", {60'd0, icap}, 64'd1);
         scan_dr(40'h1, 40, dout, en);
         chk(dout == VEC[v][39:0], $sformatf("R1 R10 chain for code %b", VEC[v][43:40]),
             {24'd0, dout}, {24'd0, VEC[v][39:0]});
      end

      // R5: debug-port write request
      scan_ir(4'b1010, icap);
      scan_dr({5'd0, 32'hDEADBEEF, 2'b10, 1'b0}, 35, dout, en);
      settle();
      chk(req_valid && !req_ap && req_addr == 2'b10 && !req_rnw && req_wdata == 32'hDEADBEEF,
          "R5 debug-port write fields",
          {req_valid, req_ap, req_addr, req_rnw, 27'd0, req_wdata},
          {1'b1, 1'b0, 2'b10, 1'b0, 27'd0, 32'hDEADBEEF});
      settle();
      chk(req_valid == 1'b0, "R5 strobe lasts one cycle", {63'd0, req_valid}, 64'd0);

      // R5: access-port read request
      scan_ir(4'b1011, icap);
      scan_dr({5'd0, 32'h0000_00F0, 2'b01, 1'b1}, 35, dout, en);
      settle();
      chk(req_valid && req_ap && req_addr == 2'b01 && req_rnw, "R5 access-port read fields",
          {59'd0, req_valid, req_ap, req_addr, req_rnw}, {59'd0, 5'b11011});

      // return a read result
      @(negedge tck);
      rsp_valid = 1'b1;
      rsp_rdata = 32'h1234_5678;
      @(negedge tck);
      rsp_valid = 1'b0;
      rsp_rdata = 32'hFFFF_FFFF;

      // R6 result on next scan; R7 this request is dropped
      port_busy = 1'b1;
      scan_ir(4'b1010, icap);
      scan_dr({5'd0, 32'hCAFE_0001, 2'b11, 1'b1}, 35, dout, en);
      chk(dout[34:3] == 32'h1234_5678, "R6 previous read data returned",
          {32'd0, dout[34:3]}, 64'h1234_5678);
      chk(dout[2:0] == 3'b010, "R6 acknowledge OK", {61'd0, dout[2:0]}, 64'd2);
      settle();
      chk(req_valid == 1'b0, "R7 busy drops request", {63'd0, req_valid}, 64'd0);
      port_busy = 1'b0;

      scan_dr({5'd0, 32'h0, 2'b01, 1'b1}, 35, dout, en);
      chk(dout[2:0] == 3'b001, "R7 WAIT after dropped request", {61'd0, dout[2:0]}, 64'd1);
      settle();
      chk(req_valid == 1'b1, "R7 request accepted once idle", {63'd0, req_valid}, 64'd1);
      scan_dr({5'd0, 32'h0, 2'b01, 1'b1}, 35, dout, en);
      chk(dout[2:0] == 3'b010, "R7 OK restored", {61'd0, dout[2:0]}, 64'd2);

      // R8: abort while busy
      port_busy = 1'b1;
      scan_ir(4'b1000, icap);
      scan_dr({5'd0, 32'h0000_0001, 3'b000}, 35, dout, en);
      chk(dout[34:0] == 35'd0, "R8 abort capture zero", {29'd0, dout[34:0]}, 64'd0);
      settle();
      chk(abort_req && !req_valid, "R8 abort strobe", {62'd0, abort_req, req_valid}, 64'd2);
      settle();
      chk(abort_req == 1'b0, "R8 abort one cycle", {63'd0, abort_req}, 64'd0);
      scan_dr({5'd0, 32'hFFFF_FFFE, 3'b111}, 35, dout, en);
      settle();
      chk(abort_req == 1'b0, "R8 flag clear gives no abort", {63'd0, abort_req}, 64'd0);
      port_busy = 1'b0;

      // R3: Test-Logic-Reset via TMS restores identification
      scan_ir(4'b1111, icap);
      for (int k = 0; k < 5; k++) tclk(1, 0, b);
      tclk(0, 0, b);
      scan_dr(40'h0, 32, dout, en);
      chk(dout[31:0] == 32'h3BA00477, "R3 TMS reset selects identification",
          {24'd0, dout}, 64'h3BA00477);

      // R3: asynchronous reset restores identification
      scan_ir(4'b1010, icap);
      @(negedge tck);
      trst_n = 1'b0;
      tms = 1'b0;
      @(negedge tck);
      trst_n = 1'b1;
      tclk(0, 0, b);
      scan_dr(40'h0, 32, dout, en);
      chk(dout[31:0] == 32'h3BA00477, "R3 trst_n selects identification",
          {24'd0, dout}, 64'h3BA00477);

      chk(edge_moved == 1'b0, "R9 TDO stable across rising edges", {63'd0, edge_moved}, 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge tck);
      total++;
      bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule